// File: doc/BRIEF.md
# Per-Function Reset Responder with Request Gating

This block sits on the application side of an endpoint. It answers reset requests that arrive separately for each function. For every function it keeps a count of the requests that have been handed to the bus and have not yet been answered. When the controller raises a function's busy line, the block stops new traffic from that function. It waits until that function's count reaches zero, then raises the function's acknowledge. The acknowledge stays high until the busy line falls, and then drops.

While a function is being reset, the block handles its two request channels differently. A write that was already handed to the bus runs to its normal completion. A new write from that function is taken off the application channel and never reaches the bus. A new read from that function is answered inside the block with a slave-error code. A read response that comes back from the bus for that function is also turned into a slave-error. Traffic from the function starts again only after its bus-master-enable input is high.

Each function runs its own four-state sequence. The states are `ST_IDLE`, `ST_DRAIN`, `ST_ACK` and `ST_WAIT_BME`. The transitions are:
- *start*: from `ST_IDLE` to `ST_DRAIN` when busy is high.
- *drained*: from `ST_DRAIN` to `ST_ACK` when the count is zero.
- *released*: from `ST_ACK` to `ST_WAIT_BME` when busy is low.
- *re-enabled*: from `ST_WAIT_BME` to `ST_IDLE` when the enable input is high.

The sequences of different functions run independently. Addresses pass through the block untouched.

Top module: `fn_reset_responder`

## Requirements
- R1: `fn_ack_o[n]` rises only when function n has no outstanding request. If nothing is outstanding, it rises on the second clock edge after `fn_busy_i[n]` is seen high. Otherwise it rises one edge after the edge that retires the last response.
- R2: Once `fn_ack_o[n]` is high, it stays high for as long as `fn_busy_i[n]` stays high. It falls on the first edge at which `fn_busy_i[n]` is seen low.
- R3: Writes accepted by the bus before a reset keep counting as outstanding. Their write responses (`bus_b_valid_i` with `bus_b_fn_i`) retire them, and the acknowledge waits for those responses.
- R4: While function n is not in `ST_IDLE`, a write request from it gives `bus_aw_valid_o`=0 and `app_aw_ready_o`=1. The write is consumed and is not forwarded.
- R5: While function n is not in `ST_IDLE`, a read request from it is not forwarded. If the error slot is empty, `app_ar_ready_o`=1. In the next cycle the block drives `app_r_valid_o`=1, `app_r_fn_o`=n and `app_r_resp_o`=2'b10 (slave-error). A bus read response for such a function is also passed on with code 2'b10. Responses for a function in `ST_IDLE` keep the bus code.
- R6: After the acknowledge is released, function n stays gated while `bme_i[n]` is low. It is forwarded again one edge after `bme_i[n]` is seen high.
- R7: A reset of one function has no effect on forwarding for any other function.
- R8: Forwarded requests carry the application address and function number unchanged on `bus_aw_addr_o`, `bus_aw_fn_o`, `bus_ar_addr_o` and `bus_ar_fn_o`.
- R9: When a function reaches 2^CNT_W-2 outstanding requests, its new requests are held: valid toward the bus is 0 and ready toward the application is 0.
- R10: After reset, all acknowledges are 0, all functions are in `ST_IDLE` with nothing outstanding, and `app_r_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fn_busy_i | input | NUM_FN | Per-function reset in progress, from the controller |
| fn_ack_o | output | NUM_FN | Per-function reset acknowledge |
| bme_i | input | NUM_FN | Per-function bus master enable |
| app_aw_valid_i | input | 1 | Application write request valid |
| app_aw_fn_i | input | FN_W | Function issuing the write |
| app_aw_addr_i | input | ADDR_W | Write address |
| app_aw_ready_o | output | 1 | Write request taken |
| bus_aw_valid_o | output | 1 | Write request toward the bus |
| bus_aw_addr_o | output | ADDR_W | Forwarded write address |
| bus_aw_fn_o | output | FN_W | Forwarded write function |
| bus_aw_ready_i | input | 1 | Bus accepts write |
| app_ar_valid_i | input | 1 | Application read request valid |
| app_ar_fn_i | input | FN_W | Function issuing the read |
| app_ar_addr_i | input | ADDR_W | Read address |
| app_ar_ready_o | output | 1 | Read request taken |
| bus_ar_valid_o | output | 1 | Read request toward the bus |
| bus_ar_addr_o | output | ADDR_W | Forwarded read address |
| bus_ar_fn_o | output | FN_W | Forwarded read function |
| bus_ar_ready_i | input | 1 | Bus accepts read |
| bus_b_valid_i | input | 1 | Write response from the bus |
| bus_b_fn_i | input | FN_W | Function of the write response |
| bus_r_valid_i | input | 1 | Read response from the bus |
| bus_r_fn_i | input | FN_W | Function of the read response |
| bus_r_resp_i | input | 2 | Bus read response code |
| app_r_valid_o | output | 1 | Read response to the application |
| app_r_fn_o | output | FN_W | Function of the read response |
| app_r_resp_o | output | 2 | Read response code (2'b10 is slave-error) |

## Verification
The bench builds the block with NUM_FN=4, CNT_W=3 and ADDR_W=16. With four functions, one function can be under reset while a neighbour is still forwarded, and two resets can overlap. A 3-bit counter puts the hold limit at six outstanding requests, so the stall at the limit can be reached in a few cycles and then drained again. The bench also covers a write still in flight that delays the acknowledge, a locally generated read error, and a bus read response that is rewritten to slave-error.

// File: rtl/frr_pkg.sv
package frr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_DRAIN    = 2'd1,
        ST_ACK      = 2'd2,
        ST_WAIT_BME = 2'd3
    } frr_state_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

endpackage

// File: rtl/frr_fn_ctrl.sv
module frr_fn_ctrl
    import frr_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic bme_i,
    input  logic iss_wr_i,
    input  logic iss_rd_i,
    input  logic ret_wr_i,
    input  logic ret_rd_i,
    output logic open_o,
    output logic full_o,
    output logic ack_o
);

    localparam logic [CNT_W-1:0] FULL_AT = CNT_W'((1 << CNT_W) - 2);

    frr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // outstanding request counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(iss_wr_i) + CNT_W'(iss_rd_i)
                           - CNT_W'(ret_wr_i) - CNT_W'(ret_rd_i);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (busy_i)         state_d = ST_DRAIN;
            ST_DRAIN:    if (cnt_q == '0)    state_d = ST_ACK;
            ST_ACK:      if (!busy_i)        state_d = ST_WAIT_BME;
            ST_WAIT_BME: if (bme_i)          state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        open_o = 1'b0;
        ack_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:     open_o = 1'b1;
            ST_DRAIN:    ;
            ST_ACK:      ack_o  = 1'b1;
            ST_WAIT_BME: ;
            default:     ;
        endcase
        full_o = (cnt_q >= FULL_AT);
    end

    p_ack_after_drain_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> (cnt_q == '0));

    p_ack_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && busy_i) |=> ack_o);

    p_ack_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !busy_i) |=> !ack_o);

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |-> !(ret_wr_i || ret_rd_i));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q >= FULL_AT) |-> !(iss_wr_i || iss_rd_i));

    p_reopen_needs_bme_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(bme_i));

endmodule

// File: rtl/frr_rd_err.sv
module frr_rd_err #(
    parameter int FN_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_i,
    input  logic [FN_W-1:0] take_fn_i,
    input  logic            bus_busy_i,
    output logic            pend_o,
    output logic [FN_W-1:0] fn_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
            fn_o   <= '0;
        end else if (take_i) begin
            pend_o <= 1'b1;
            fn_o   <= take_fn_i;
        end else if (pend_o && !bus_busy_i) begin
            pend_o <= 1'b0;
        end
    end

    p_slot_no_clobber_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> !pend_o);

endmodule

// File: rtl/fn_reset_responder.sv
module fn_reset_responder
    import frr_pkg::*;
#(
    parameter int NUM_FN = 4,
    parameter int CNT_W  = 3,
    parameter int ADDR_W = 16,
    parameter int FN_W   = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_FN-1:0] fn_busy_i,
    output logic [NUM_FN-1:0] fn_ack_o,
    input  logic [NUM_FN-1:0] bme_i,
    input  logic              app_aw_valid_i,
    input  logic [FN_W-1:0]   app_aw_fn_i,
    input  logic [ADDR_W-1:0] app_aw_addr_i,
    output logic              app_aw_ready_o,
    output logic              bus_aw_valid_o,
    output logic [ADDR_W-1:0] bus_aw_addr_o,
    output logic [FN_W-1:0]   bus_aw_fn_o,
    input  logic              bus_aw_ready_i,
    input  logic              app_ar_valid_i,
    input  logic [FN_W-1:0]   app_ar_fn_i,
    input  logic [ADDR_W-1:0] app_ar_addr_i,
    output logic              app_ar_ready_o,
    output logic              bus_ar_valid_o,
    output logic [ADDR_W-1:0] bus_ar_addr_o,
    output logic [FN_W-1:0]   bus_ar_fn_o,
    input  logic              bus_ar_ready_i,
    input  logic              bus_b_valid_i,
    input  logic [FN_W-1:0]   bus_b_fn_i,
    input  logic              bus_r_valid_i,
    input  logic [FN_W-1:0]   bus_r_fn_i,
    input  logic [1:0]        bus_r_resp_i,
    output logic              app_r_valid_o,
    output logic [FN_W-1:0]   app_r_fn_o,
    output logic [1:0]        app_r_resp_o
);

    localparam int SLOTS = 1 << FN_W;

    logic [SLOTS-1:0] open_v, full_v, ack_v;
    logic             aw_open, aw_full, ar_open, ar_full;
    logic             err_pend, err_take;
    logic [FN_W-1:0]  err_fn;

    assign aw_open = open_v[app_aw_fn_i];
    assign aw_full = full_v[app_aw_fn_i];
    assign ar_open = open_v[app_ar_fn_i];
    assign ar_full = full_v[app_ar_fn_i];

    // write channel: forward when open, swallow when gated
    always_comb begin
        bus_aw_valid_o = app_aw_valid_i && aw_open && !aw_full;
        bus_aw_addr_o  = app_aw_addr_i;
        bus_aw_fn_o    = app_aw_fn_i;
        app_aw_ready_o = aw_open ? (bus_aw_ready_i && !aw_full) : 1'b1;
    end

    // read channel: forward when open, local error when gated
    always_comb begin
        bus_ar_valid_o = app_ar_valid_i && ar_open && !ar_full;
        bus_ar_addr_o  = app_ar_addr_i;
        bus_ar_fn_o    = app_ar_fn_i;
        app_ar_ready_o = ar_open ? (bus_ar_ready_i && !ar_full) : !err_pend;
        err_take       = app_ar_valid_i && !ar_open && !err_pend;
    end

    // read response merge: bus first, local error slot otherwise
    always_comb begin
        app_r_valid_o = bus_r_valid_i || err_pend;
        if (bus_r_valid_i) begin
            app_r_fn_o   = bus_r_fn_i;
            app_r_resp_o = open_v[bus_r_fn_i] ? bus_r_resp_i : RESP_SLVERR;
        end else begin
            app_r_fn_o   = err_fn;
            app_r_resp_o = RESP_SLVERR;
        end
    end

    frr_rd_err #(.FN_W(FN_W)) u_rd_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (err_take),
        .take_fn_i  (app_ar_fn_i),
        .bus_busy_i (bus_r_valid_i),
        .pend_o     (err_pend),
        .fn_o       (err_fn)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_fn
        if (g < NUM_FN) begin : g_live
            frr_fn_ctrl #(.CNT_W(CNT_W)) u_ctrl (
                .clk      (clk),
                .rst_n    (rst_n),
                .busy_i   (fn_busy_i[g]),
                .bme_i    (bme_i[g]),
                .iss_wr_i (bus_aw_valid_o && bus_aw_ready_i && (app_aw_fn_i == FN_W'(g))),
                .iss_rd_i (bus_ar_valid_o && bus_ar_ready_i && (app_ar_fn_i == FN_W'(g))),
                .ret_wr_i (bus_b_valid_i && (bus_b_fn_i == FN_W'(g))),
                .ret_rd_i (bus_r_valid_i && (bus_r_fn_i == FN_W'(g))),
                .open_o   (open_v[g]),
                .full_o   (full_v[g]),
                .ack_o    (ack_v[g])
            );
        end else begin : g_absent
            // unused function numbers behave as permanently gated
            assign open_v[g] = 1'b0;
            assign full_v[g] = 1'b0;
            assign ack_v[g]  = 1'b0;
        end
    end

    assign fn_ack_o = ack_v[NUM_FN-1:0];

    p_wr_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_aw_valid_o |-> !ack_v[app_aw_fn_i]);

    p_rd_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ar_valid_o |-> !ack_v[app_ar_fn_i]);

    p_local_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (app_ar_valid_i && app_ar_ready_o && !ar_open)
        |=> (bus_r_valid_i || (app_r_valid_o && app_r_resp_o == RESP_SLVERR)));

endmodule

// File: tb/fn_reset_responder_test.sv
module fn_reset_responder_test;

    localparam int NUM_FN = 4;
    localparam int CNT_W  = 3;
    localparam int ADDR_W = 16;
    localparam int FN_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NUM_FN-1:0] fn_busy_i, fn_ack_o, bme_i;
    logic              app_aw_valid_i, app_aw_ready_o, bus_aw_valid_o, bus_aw_ready_i;
    logic [FN_W-1:0]   app_aw_fn_i, bus_aw_fn_o;
    logic [ADDR_W-1:0] app_aw_addr_i, bus_aw_addr_o;
    logic              app_ar_valid_i, app_ar_ready_o, bus_ar_valid_o, bus_ar_ready_i;
    logic [FN_W-1:0]   app_ar_fn_i, bus_ar_fn_o;
    logic [ADDR_W-1:0] app_ar_addr_i, bus_ar_addr_o;
    logic              bus_b_valid_i, bus_r_valid_i, app_r_valid_o;
    logic [FN_W-1:0]   bus_b_fn_i, bus_r_fn_i, app_r_fn_o;
    logic [1:0]        bus_r_resp_i, app_r_resp_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    fn_reset_responder #(.NUM_FN(NUM_FN), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .fn_busy_i(fn_busy_i), .fn_ack_o(fn_ack_o), .bme_i(bme_i),
        .app_aw_valid_i(app_aw_valid_i), .app_aw_fn_i(app_aw_fn_i), .app_aw_addr_i(app_aw_addr_i),
        .app_aw_ready_o(app_aw_ready_o), .bus_aw_valid_o(bus_aw_valid_o),
        .bus_aw_addr_o(bus_aw_addr_o), .bus_aw_fn_o(bus_aw_fn_o), .bus_aw_ready_i(bus_aw_ready_i),
        .app_ar_valid_i(app_ar_valid_i), .app_ar_fn_i(app_ar_fn_i), .app_ar_addr_i(app_ar_addr_i),
        .app_ar_ready_o(app_ar_ready_o), .bus_ar_valid_o(bus_ar_valid_o),
        .bus_ar_addr_o(bus_ar_addr_o), .bus_ar_fn_o(bus_ar_fn_o), .bus_ar_ready_i(bus_ar_ready_i),
        .bus_b_valid_i(bus_b_valid_i), .bus_b_fn_i(bus_b_fn_i),
        .bus_r_valid_i(bus_r_valid_i), .bus_r_fn_i(bus_r_fn_i), .bus_r_resp_i(bus_r_resp_i),
        .app_r_valid_o(app_r_valid_o), .app_r_fn_o(app_r_fn_o), .app_r_resp_o(app_r_resp_o)
    );

    typedef struct packed {
        logic              v;
        logic [FN_W-1:0]   fn;
        logic [ADDR_W-1:0] addr;
        logic              rdy;
        logic              exp_v;
        logic              exp_rdy;
    } vec_t;

    // idle-state write forwarding vectors (R7, R8)
    localparam vec_t VEC [0:5] = '{
        '{1'b1, 2'd0, 16'h1234, 1'b1, 1'b1, 1'b1},
        '{1'b1, 2'd3, 16'hABCD, 1'b0, 1'b1, 1'b0},
        '{1'b0, 2'd2, 16'h0000, 1'b1, 1'b0, 1'b1},
        '{1'b1, 2'd1, 16'hFFFF, 1'b1, 1'b1, 1'b1},
        '{1'b1, 2'd2, 16'h8001, 1'b0, 1'b1, 1'b0},
        '{1'b0, 2'd1, 16'h5A5A, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        app_aw_valid_i = 0; app_aw_fn_i = 0; app_aw_addr_i = 0; bus_aw_ready_i = 0;
        app_ar_valid_i = 0; app_ar_fn_i = 0; app_ar_addr_i = 0; bus_ar_ready_i = 0;
        bus_b_valid_i = 0; bus_b_fn_i = 0;
        bus_r_valid_i = 0; bus_r_fn_i = 0; bus_r_resp_i = 0;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; fn_busy_i = '0; bme_i = '1;
        idle_inputs();
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R10 reset state
        chk("R10 ack after reset", 32'(fn_ack_o), 32'h0);
        chk("R10 r valid after reset", 32'(app_r_valid_o), 32'h0);

        // R8 / R7 table walk, no edge while valid
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            app_aw_valid_i = VEC[i].v; app_aw_fn_i = VEC[i].fn;
            app_aw_addr_i = VEC[i].addr; bus_aw_ready_i = VEC[i].rdy;
            #1;
            chk("R7 table aw valid", 32'(bus_aw_valid_o), 32'(VEC[i].exp_v));
            chk("R7 table aw ready", 32'(app_aw_ready_o), 32'(VEC[i].exp_rdy));
            if (VEC[i].exp_v) begin
                chk("R8 table addr", 32'(bus_aw_addr_o), 32'(VEC[i].addr));
                chk("R8 table fn", 32'(bus_aw_fn_o), 32'(VEC[i].fn));
            end
            #1;
            idle_inputs();
        end
        tick();

        // R3: write in flight on fn1, then reset fn1
        app_aw_valid_i = 1; app_aw_fn_i = 1; bus_aw_ready_i = 1; app_aw_addr_i = 16'h0040;
        tick();
        idle_inputs();
        fn_busy_i[1] = 1; bme_i[1] = 0;
        repeat (4) tick();
        chk("R3 ack waits for write response", 32'(fn_ack_o[1]), 32'h0);

        // R4 blocked write on fn1; R7 fn2 still forwarded
        app_aw_valid_i = 1; app_aw_fn_i = 1; bus_aw_ready_i = 1;
        #1;
        chk("R4 gated write not forwarded", 32'(bus_aw_valid_o), 32'h0);
        chk("R4 gated write consumed", 32'(app_aw_ready_o), 32'h1);
        app_aw_fn_i = 2; bus_aw_ready_i = 0;
        #1;
        chk("R7 other function forwarded", 32'(bus_aw_valid_o), 32'h1);
        idle_inputs();

        // R5 local read error for fn1
        app_ar_valid_i = 1; app_ar_fn_i = 1; bus_ar_ready_i = 1;
        #1;
        chk("R5 gated read not forwarded", 32'(bus_ar_valid_o), 32'h0);
        chk("R5 gated read taken", 32'(app_ar_ready_o), 32'h1);
        tick();
        idle_inputs();
        chk("R5 local error valid", 32'(app_r_valid_o), 32'h1);
        chk("R5 local error fn", 32'(app_r_fn_o), 32'h1);
        chk("R5 local error code", 32'(app_r_resp_o), 32'h2);
        tick();
        chk("R5 local error single cycle", 32'(app_r_valid_o), 32'h0);

        // R1: retire the in-flight write
        bus_b_valid_i = 1; bus_b_fn_i = 1;
        tick();
        idle_inputs();
        chk("R1 ack not yet on drain edge", 32'(fn_ack_o[1]), 32'h0);
        tick();
        chk("R1 ack after drain", 32'(fn_ack_o[1]), 32'h1);

        // R2 hold and release
        repeat (3) tick();
        chk("R2 ack held while busy", 32'(fn_ack_o[1]), 32'h1);
        fn_busy_i[1] = 0;
        #1;
        chk("R2 ack unchanged before edge", 32'(fn_ack_o[1]), 32'h1);
        tick();
        chk("R2 ack released", 32'(fn_ack_o[1]), 32'h0);

        // R6 gated until bme
        repeat (2) tick();
        app_aw_valid_i = 1; app_aw_fn_i = 1;
        #1;
        chk("R6 blocked without bme", 32'(bus_aw_valid_o), 32'h0);
        idle_inputs();
        bme_i[1] = 1;
        tick();
        app_aw_valid_i = 1; app_aw_fn_i = 1;
        #1;
        chk("R6 resumed after bme", 32'(bus_aw_valid_o), 32'h1);
        idle_inputs();

        // R5 in-flight read response rewritten; R1 zero-outstanding timing on fn2
        app_ar_valid_i = 1; app_ar_fn_i = 3; bus_ar_ready_i = 1;
        tick();
        idle_inputs();
        fn_busy_i[3] = 1; bme_i[3] = 0;
        fn_busy_i[2] = 1; bme_i[2] = 0;
        tick();
        chk("R1 fn2 ack not after one edge", 32'(fn_ack_o[2]), 32'h0);
        tick();
        chk("R1 fn2 ack after two edges", 32'(fn_ack_o[2]), 32'h1);
        chk("R1 fn3 ack waits for read", 32'(fn_ack_o[3]), 32'h0);
        bus_r_valid_i = 1; bus_r_fn_i = 3; bus_r_resp_i = 2'b00;
        #1;
        chk("R5 in-flight response valid", 32'(app_r_valid_o), 32'h1);
        chk("R5 in-flight response code", 32'(app_r_resp_o), 32'h2);
        tick();
        idle_inputs();
        tick();
        chk("R1 fn3 ack after read drained", 32'(fn_ack_o[3]), 32'h1);
        fn_busy_i[3] = 0; fn_busy_i[2] = 0;
        tick();
        bme_i[3] = 1; bme_i[2] = 1;
        tick();

        // R9 hold at the outstanding limit on fn0
        app_aw_valid_i = 1; app_aw_fn_i = 0; bus_aw_ready_i = 1;
        repeat (5) tick();
        #1;
        chk("R9 forwarded below limit", 32'(bus_aw_valid_o), 32'h1);
        tick();
        #1;
        chk("R9 held at limit valid", 32'(bus_aw_valid_o), 32'h0);
        chk("R9 held at limit ready", 32'(app_aw_ready_o), 32'h0);
        idle_inputs();
        bus_b_valid_i = 1; bus_b_fn_i = 0;
        repeat (6) tick();
        idle_inputs();

        // R5 open function keeps bus code
        app_ar_valid_i = 1; app_ar_fn_i = 0; bus_ar_ready_i = 1;
        tick();
        idle_inputs();
        bus_r_valid_i = 1; bus_r_fn_i = 0; bus_r_resp_i = 2'b01;
        #1;
        chk("R5 open function code kept", 32'(app_r_resp_o), 32'h1);
        tick();
        idle_inputs();
        tick();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule